// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block is the power-mode controller of a small processor core. While the core runs, a sleep-instruction strobe puts it into a deep standby state, but only when two control bits (stop enable and standby enable) are both set. In standby the oscillator enable and the core clock enable are both dropped. The block runs on a free-running reference clock, so it can still see wake events while the core clock is stopped.

A wake event is one of three things: NMI, an active-low maskable interrupt line whose enable bit is set, or an external bus request when external bus grants are enabled. The first wake event turns the oscillator back on and starts a stabilization count. The quick-recovery bit picks the length of that count: 64 cycles when set, 131072 cycles when clear. The core clock enable returns when the count expires. If the wake was a bus request, the bus acknowledge is raised at the same moment.

An asynchronous active-low reset also ends standby at once, with no count. External logic is expected to hold reset low until the oscillator is stable. Reset also forces the clock divider to divide-by-two. All control and status pins are plain levels; the block has no streaming interface, so there is no valid/ready back-pressure to observe.

Top module: `stby_wake_ctrl`

## Requirements
- R1: Standby is entered on a reference-clock edge where `sleep_stb`, `ctl_stop_en` and `ctl_stby_en` are all 1. If either control bit is 0, the strobe leaves the block running, with `core_clk_en`=1 and `stby_flag`=0.
- R2: From the edge that enters standby until a wake event is detected, `osc_en` and `core_clk_en` are both 0.
- R3: The wake sources are `nmi`=1 and any `irq_n[i]`=0 whose `irq_en[i]`=1. A line held low with its enable bit at 0 does not wake the block.
- R4: Each wake input passes through two synchronizer flops. The wake is acted on at the third reference edge after the input changes, and `osc_en` rises at that edge. `core_clk_en` rises N edges later, where N=64 when `ctl_quick`=1 and N=131072 when `ctl_quick`=0.
- R5: With `ctl_bus_ext`=1, `bus_req`=1 during standby wakes the block. `bus_ack` rises together with `core_clk_en`, after the same N-cycle count, and stays high while `bus_req` stays 1. With `ctl_bus_ext`=0, `bus_req` does not wake the block.
- R6: `div2_sel` is the registered inverse of `ctl_div1`: 1 selects divide-by-two, 0 selects divide-by-one. While `rst_n`=0, `div2_sel` is 1.
- R7: `rst_n`=0 immediately sets `osc_en`=1, `core_clk_en`=1, `stby_flag`=0 and `bus_ack`=0, including from standby, and adds no stabilization count.
- R8: A further wake event while the count is running does not restart the count.
- R9: `stby_flag` is 1 from the edge that enters standby until the edge where `core_clk_en` returns to 1. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; also a wake path |
| sleep_stb | input | 1 | One-cycle sleep-instruction strobe |
| ctl_stop_en | input | 1 | Stop enable control bit |
| ctl_stby_en | input | 1 | Standby enable control bit |
| ctl_quick | input | 1 | 1 selects the 64-cycle count, 0 the 131072-cycle count |
| ctl_bus_ext | input | 1 | Allows a bus request to be granted from standby |
| ctl_div1 | input | 1 | Clock divide bit: 1 selects divide-by-one |
| nmi | input | 1 | Non-maskable interrupt, active high |
| irq_n | input | 3 | Maskable interrupt lines, active low |
| irq_en | input | 3 | Per-line enables for `irq_n` |
| bus_req | input | 1 | External bus request |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| div2_sel | output | 1 | 1 selects divide-by-two |
| bus_ack | output | 1 | Bus acknowledge |
| stby_flag | output | 1 | Standby / recovery status |

## Verification
The bench counts the exact edge at which `core_clk_en` returns, for both count lengths. A design that is off by one, that ignores the synchronizer delay, or that swaps the meaning of the quick bit would show the clock one edge early or late. It then sends a second wake partway through a count; a design that reloads its counter would bring the clock back late. It drives interrupt lines low with their enables cleared, strobes sleep with only one control bit set, and raises bus requests with grants disabled. A design that decodes any of these loosely would leave standby, or enter it, when it must not. A reset in the middle of standby must restore the clocks at once; a design that routes reset through the count would keep them off.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_STBY = 2'd1,
    PM_WARM = 2'd2
  } pm_state_e;

  localparam int unsigned IRQ_LINES = 3;
  localparam int unsigned SYNC_W    = IRQ_LINES + 2;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= IDLE[i];
        q[i]    <= IDLE[i];
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(d) != q |-> 1'b1 ##0 ($past(d, 2) == q || !$past(rst_n, 2) || !$past(rst_n))); // R4
endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
  parameter int unsigned CNT_W  = 17,
  parameter int unsigned SLOW_N = 131072,
  parameter int unsigned FAST_N = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic quick,
  output logic busy,
  output logic done
);
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_N - 1);
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_N - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load && !busy) begin
      cnt  <= quick ? FAST_LD : SLOW_LD;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  AST_CNT_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(cnt) != '0) |-> (busy && cnt == $past(cnt) - 1'b1)); // R8

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R8
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned CNT_W  = 17,
  parameter int unsigned SLOW_N = 131072,
  parameter int unsigned FAST_N = 64
) (
  input  logic                 ref_clk,
  input  logic                 rst_n,
  input  logic                 sleep_stb,
  input  logic                 ctl_stop_en,
  input  logic                 ctl_stby_en,
  input  logic                 ctl_quick,
  input  logic                 ctl_bus_ext,
  input  logic                 ctl_div1,
  input  logic                 nmi,
  input  logic [IRQ_LINES-1:0] irq_n,
  input  logic [IRQ_LINES-1:0] irq_en,
  input  logic                 bus_req,
  output logic                 osc_en,
  output logic                 core_clk_en,
  output logic                 div2_sel,
  output logic                 bus_ack,
  output logic                 stby_flag
);
  localparam logic [SYNC_W-1:0] SYNC_IDLE = {2'b00, {IRQ_LINES{1'b1}}};

  pm_state_e         state_q;
  logic [SYNC_W-1:0] sy;
  logic              nmi_s, bus_s, irq_wake, bus_wake, wake_any;
  logic              cnt_load, cnt_busy, cnt_done;
  logic              grant_q, div1_q;

  wake_sync #(.W(SYNC_W), .IDLE(SYNC_IDLE)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     ({bus_req, nmi, irq_n}),
    .q     (sy)
  );

  assign irq_wake = |(~sy[IRQ_LINES-1:0] & irq_en);
  assign nmi_s    = sy[IRQ_LINES];
  assign bus_s    = sy[IRQ_LINES+1];
  assign bus_wake = bus_s && ctl_bus_ext;
  assign wake_any = nmi_s || irq_wake || bus_wake;
  assign cnt_load = (state_q == PM_STBY) && wake_any;

  stab_counter #(.CNT_W(CNT_W), .SLOW_N(SLOW_N), .FAST_N(FAST_N)) u_cnt (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .load  (cnt_load),
    .quick (ctl_quick),
    .busy  (cnt_busy),
    .done  (cnt_done)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      grant_q <= 1'b0;
    end else begin
      unique case (state_q)
        PM_RUN: begin
          if (!bus_s) grant_q <= 1'b0;
          if (sleep_stb && ctl_stop_en && ctl_stby_en) state_q <= PM_STBY;
        end
        PM_STBY: begin
          if (wake_any) begin
            state_q <= PM_WARM;
            grant_q <= bus_wake;
          end
        end
        PM_WARM: begin
          if (cnt_done) state_q <= PM_RUN;
        end
        default: state_q <= PM_RUN;
      endcase
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) div1_q <= 1'b0;
    else        div1_q <= ctl_div1;
  end

  assign osc_en      = (state_q != PM_STBY);
  assign core_clk_en = (state_q == PM_RUN);
  assign stby_flag   = (state_q != PM_RUN);
  assign bus_ack     = (state_q == PM_RUN) && grant_q && bus_s;
  assign div2_sel    = !div1_q;

  AST_ENTRY_NEEDS_BOTH: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(sleep_stb && ctl_stop_en && ctl_stby_en)); // R1

  AST_NO_CLK_WITHOUT_OSC: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !osc_en |-> !core_clk_en); // R2

  AST_WAKE_HAS_CAUSE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(osc_en) |-> $past(wake_any)); // R3

  AST_CLK_AFTER_COUNT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> $past(cnt_done)); // R4

  AST_ACK_FROM_STANDBY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(stby_flag)); // R5
endmodule

// File: tb/sim_stby_wake_ctrl.sv
`timescale 1ns/1ps
module sim_stby_wake_ctrl;
  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_stb = 0, ctl_stop_en = 0, ctl_stby_en = 0, ctl_quick = 1;
  logic ctl_bus_ext = 0, ctl_div1 = 0, nmi = 0, bus_req = 0;
  logic [2:0] irq_n = 3'b111, irq_en = 3'b000;
  logic osc_en, core_clk_en, div2_sel, bus_ack, stby_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2.5 ref_clk = ~ref_clk;

  stby_wake_ctrl u0 (.*);

  // {stop, stby, irq_n[2:0], irq_en[2:0], nmi, expect_standby, expect_wake}
  localparam logic [10:0] VEC [9] = '{
    11'b0_1_111_000_0_0_0,
    11'b1_0_111_000_0_0_0,
    11'b0_0_111_000_0_0_0,
    11'b1_1_110_001_0_1_1,
    11'b1_1_110_110_0_1_0,
    11'b1_1_011_100_0_1_1,
    11'b1_1_111_000_1_1_1,
    11'b1_1_101_010_0_1_1,
    11'b1_1_111_111_0_1_0
  };

  task automatic tick(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic enter_standby();
    ctl_stop_en = 1; ctl_stby_en = 1; sleep_stb = 1;
    tick(1);
    sleep_stb = 0;
  endtask

  task automatic recover();
    nmi = 1;
    for (int k = 0; k < 200 && !core_clk_en; k++) tick(1);
    nmi = 0;
    tick(3);
  endtask

  initial begin
    #(195000 * 5.0);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(1);
    // R7 / R6: state while reset is held
    check("R7 osc_en in reset", osc_en, 1'b1);
    check("R7 core_clk_en in reset", core_clk_en, 1'b1);
    check("R6 div2_sel in reset", div2_sel, 1'b1);
    check("R9 stby_flag in reset", stby_flag, 1'b0);
    check("R7 bus_ack in reset", bus_ack, 1'b0);
    tick(1);
    rst_n = 1;
    tick(2);

    // Vector table: R1 entry qualification, R3 wake source masking
    foreach (VEC[i]) begin
      ctl_stop_en = VEC[i][10]; ctl_stby_en = VEC[i][9];
      sleep_stb = 1;
      tick(1);
      sleep_stb = 0;
      check($sformatf("R1 vec%0d stby_flag", i), stby_flag, VEC[i][1]);
      check($sformatf("R2 vec%0d core_clk_en", i), core_clk_en, !VEC[i][1]);
      if (VEC[i][1]) begin
        irq_n = VEC[i][8:6]; irq_en = VEC[i][5:3]; nmi = VEC[i][2];
        tick(4);
        check($sformatf("R3 vec%0d osc_en", i), osc_en, VEC[i][0]);
        irq_n = 3'b111; irq_en = 3'b000;
        recover();
      end
      tick(2);
    end

    // R4 quick count, exact edge; R9 flag during count
    ctl_quick = 1;
    enter_standby();
    irq_en = 3'b001; irq_n = 3'b110;
    tick(2);
    check("R4 osc_en before sync", osc_en, 1'b0);
    tick(1);
    check("R4 osc_en after sync", osc_en, 1'b1);
    tick(7);
    check("R9 stby_flag during count", stby_flag, 1'b1);
    tick(56);
    check("R4 quick clk_en one early", core_clk_en, 1'b0);
    tick(1);
    check("R4 quick clk_en on time", core_clk_en, 1'b1);
    check("R9 stby_flag cleared", stby_flag, 1'b0);
    irq_n = 3'b111; irq_en = 3'b000;
    tick(3);

    // R8 second wake mid-count does not restart
    enter_standby();
    nmi = 1; tick(3); nmi = 0;
    tick(27);
    irq_en = 3'b100; irq_n = 3'b011;
    tick(3); irq_n = 3'b111;
    tick(33);
    check("R8 clk_en one early", core_clk_en, 1'b0);
    tick(1);
    check("R8 clk_en not restarted", core_clk_en, 1'b1);
    irq_en = 3'b000;
    tick(3);

    // R5 bus grant from standby
    ctl_bus_ext = 1;
    enter_standby();
    bus_req = 1;
    tick(66);
    check("R5 bus_ack early", bus_ack, 1'b0);
    tick(1);
    check("R5 bus_ack on time", bus_ack, 1'b1);
    check("R5 clk_en with ack", core_clk_en, 1'b1);
    bus_req = 0;
    tick(3);
    check("R5 bus_ack drops", bus_ack, 1'b0);
    ctl_bus_ext = 0;
    enter_standby();
    bus_req = 1;
    tick(6);
    check("R5 request ignored when disabled", osc_en, 1'b0);
    bus_req = 0;
    recover();

    // R6 divide select
    ctl_div1 = 1;
    tick(1);
    check("R6 divide-by-one", div2_sel, 1'b0);

    // R7 reset wake from standby
    enter_standby();
    tick(2);
    rst_n = 0;
    #1;
    check("R7 osc_en on reset", osc_en, 1'b1);
    check("R7 clk_en on reset", core_clk_en, 1'b1);
    check("R6 div2_sel forced", div2_sel, 1'b1);
    tick(2);
    rst_n = 1;
    ctl_div1 = 0;
    tick(2);

    // R4 slow count, exact edge
    ctl_quick = 0;
    enter_standby();
    nmi = 1;
    tick(131074);
    check("R4 slow clk_en one early", core_clk_en, 1'b0);
    tick(1);
    check("R4 slow clk_en on time", core_clk_en, 1'b1);
    nmi = 0;

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule